// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block holds the timing and sequencing core of a delta-sigma converter's digital control. It counts enabled clock ticks and signals on an active-low data-ready line each time a conversion finishes. The modulator, the filter arithmetic, the serial port and the register file are not part of it. A start strobe marks the end of a start/sync command. At that strobe the block samples the operating mode, the rate index and the single-shot select. It then runs a fixed lead-in count, followed by a conversion length taken from a per-mode lookup table. In continuous operation it repeats that conversion length for as long as no new command arrives. In single-shot operation it counts one latency from the table, reports once, and goes back to idle.

If the internal oscillator is not yet running when the command ends, the count waits until the oscillator-ready input goes high. A new start strobe cancels any count in progress and starts the sequence again. A reserved mode or rate index starts no conversion and sets an error flag instead. For simulation, the parameter `PERIOD_SHIFT` divides every table length by a power of two so that long settings can be exercised in a short run. It does not affect the lead-in count. Its default of 0 gives the exact lengths.

Top module: `convseq_top`

## Requirements
- R1: After reset, `drdyN` is 1, `busy` is 0 and `rateErr` is 0.
- R2: In continuous operation, the first low edge of `drdyN` comes after lead + P enabled ticks. The lead is 210 ticks for mode 0 (normal) and mode 1 (duty-cycle), and 114 ticks for mode 2 (turbo). P is the period from R3. Counting starts at the clock edge that samples `startCmd`.
- R3: The continuous period P between successive low edges of `drdyN` comes from the table below, indexed by rate 0..6, then shifted right by `PERIOD_SHIFT`.
  - Mode 0: 204768, 91120, 46128, 23664, 12464, 6896, 4144.
  - Mode 2: 102384, 45560, 23064, 11832, 6232, 3448, 2072.
  - Mode 1: 823120, 364560, 184592, 94736, 49936, 27664, 16656.
- R4: With `singleShot`=1, `drdyN` falls a fixed latency after the start edge, indexed by rate 0..6 and shifted right by `PERIOD_SHIFT`. Modes 0 and 1 both use 204850, 91218, 46226, 23762, 12562, 6994, 4242. Mode 2 uses 102434, 45618, 23122, 11890, 6290, 3506, 2130.
- R5: A single-shot conversion produces exactly one low edge of `drdyN`. `busy` is already 0 in the cycle that `drdyN` goes low, and no further conversion follows.
- R6: `drdyN` returns to 1 on the clock edge after a `dataRead` pulse. Otherwise it returns to 1 two enabled ticks before the next low edge: it is 1 from tick P-2 of the following period.
- R7: If `oscReady` is 0 when the start strobe is sampled, no count runs. The count begins at the edge where `oscReady` is first sampled as 1.
- R8: A start with rate index 7, or with mode 3, sets `rateErr` and leaves `busy` at 0. It starts no conversion and ends any conversion in progress. The next valid start clears `rateErr`.
- R9: A start strobe during a conversion discards the current count, and all timing is measured again from the new strobe.
- R10: Ticks count only on edges where `clkEn` is 1.
- R11: Mode, rate and single-shot select are captured at the start strobe. Later changes to these inputs have no effect until the next start.
- R12: After a valid start, `busy` is 1 until a single-shot conversion completes. In continuous operation it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Modulator tick enable; one tick per edge where it is 1 |
| startCmd | input | 1 | One-cycle strobe marking the end of a start/sync command |
| opMode | input | 2 | 0 normal, 1 duty-cycle, 2 turbo, 3 reserved |
| rateSel | input | 3 | Data-rate index 0..6; 7 reserved |
| singleShot | input | 1 | 1 selects single-shot, 0 selects continuous |
| oscReady | input | 1 | Internal oscillator running |
| dataRead | input | 1 | One-cycle strobe indicating the result was read |
| drdyN | output | 1 | Active-low data-ready |
| busy | output | 1 | A conversion sequence is pending |
| rateErr | output | 1 | Last start named a reserved mode or index |

## Verification
A counter that is off by one, or a wrong table entry, moves the low edge of `drdyN` by one or more ticks. The error therefore shows in the very first conversion after a start, at the exact cycle the bench expects the edge. A wrong phase state shows as a second edge after a single-shot, as `busy` not dropping, or as a count running while the oscillator is still down. A stale captured configuration shows as a period taken from the live inputs rather than the captured ones. The bench sweeps every mode and index pair in both operating styles. It times each edge to the exact tick.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

  localparam int unsigned LONGEST_LEN = 823120;
  localparam int CNT_W = $clog2(LONGEST_LEN + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_DUTY   = 2'd1,
    MODE_TURBO  = 2'd2,
    MODE_RSVD   = 2'd3
  } opMode_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OSC,
    PH_LEAD,
    PH_CONV
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic count;
    logic leadSel;
  } seqCtl_t;

  function automatic cnt_t contPeriod(opMode_t m, logic [2:0] r);
    int unsigned v;
    v = 0;
    if (m == MODE_TURBO) begin
      case (r)
        3'd0: v = 102384;
        3'd1: v = 45560;
        3'd2: v = 23064;
        3'd3: v = 11832;
        3'd4: v = 6232;
        3'd5: v = 3448;
        3'd6: v = 2072;
        default: v = 0;
      endcase
    end else if (m == MODE_DUTY) begin
      case (r)
        3'd0: v = 823120;
        3'd1: v = 364560;
        3'd2: v = 184592;
        3'd3: v = 94736;
        3'd4: v = 49936;
        3'd5: v = 27664;
        3'd6: v = 16656;
        default: v = 0;
      endcase
    end else begin
      case (r)
        3'd0: v = 204768;
        3'd1: v = 91120;
        3'd2: v = 46128;
        3'd3: v = 23664;
        3'd4: v = 12464;
        3'd5: v = 6896;
        3'd6: v = 4144;
        default: v = 0;
      endcase
    end
    return cnt_t'(v);
  endfunction

  // duty-cycle single-shot shares the normal latencies
  function automatic cnt_t singleLatency(opMode_t m, logic [2:0] r);
    int unsigned v;
    v = 0;
    if (m == MODE_TURBO) begin
      case (r)
        3'd0: v = 102434;
        3'd1: v = 45618;
        3'd2: v = 23122;
        3'd3: v = 11890;
        3'd4: v = 6290;
        3'd5: v = 3506;
        3'd6: v = 2130;
        default: v = 0;
      endcase
    end else begin
      case (r)
        3'd0: v = 204850;
        3'd1: v = 91218;
        3'd2: v = 46226;
        3'd3: v = 23762;
        3'd4: v = 12562;
        3'd5: v = 6994;
        3'd6: v = 4242;
        default: v = 0;
      endcase
    end
    return cnt_t'(v);
  endfunction

endpackage

// File: rtl/convseq_datapath.sv
module convseq_datapath
  import convseq_pkg::*;
#(
  parameter int PERIOD_SHIFT = 0,
  parameter int unsigned LEAD_NORMAL = 210,
  parameter int unsigned LEAD_TURBO = 114
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqCtl_t    ctl,
  input  logic [1:0] modeIn,
  input  logic [2:0] rateIn,
  input  logic       singleIn,
  output logic       done,
  output logic       nearEnd,
  output logic       singleQ
);

  opMode_t    modeQ;
  logic [2:0] rateQ;
  cnt_t       cnt;
  cnt_t       convLen;
  cnt_t       target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_NORMAL;
      rateQ   <= '0;
      singleQ <= 1'b0;
    end else if (ctl.load) begin
      modeQ   <= opMode_t'(modeIn);
      rateQ   <= rateIn;
      singleQ <= singleIn;
    end
  end

  always_comb begin
    if (singleQ) convLen = singleLatency(modeQ, rateQ) >> PERIOD_SHIFT;
    else         convLen = contPeriod(modeQ, rateQ) >> PERIOD_SHIFT;
    if (ctl.leadSel)
      target = (modeQ == MODE_TURBO) ? cnt_t'(LEAD_TURBO) : cnt_t'(LEAD_NORMAL);
    else
      target = convLen;
  end

  assign done    = ctl.count && (cnt == target - cnt_t'(1));
  assign nearEnd = ctl.count && (cnt == target - cnt_t'(3));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (ctl.clear) cnt <= '0;
    else if (ctl.count) cnt <= done ? '0 : cnt + cnt_t'(1);
  end

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    cnt < target); // R3

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.count && !ctl.clear) |=> $stable(cnt)); // R10

endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
  import convseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       startCmd,
  input  logic [1:0] modeIn,
  input  logic [2:0] rateIn,
  input  logic       singleIn,
  input  logic       oscReady,
  input  logic       dataRead,
  input  logic       done,
  input  logic       nearEnd,
  input  logic       singleQ,
  output seqCtl_t    ctl,
  output logic       drdyN,
  output logic       busy,
  output logic       rateErr
);

  phase_t phase;
  logic   counting;
  logic   cfgBad;

  assign counting = (phase == PH_LEAD) || (phase == PH_CONV);
  assign cfgBad   = (rateIn == 3'd7) || (modeIn == 2'd3);
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    ctl.load    = startCmd && !cfgBad;
    ctl.clear   = startCmd || !counting;
    ctl.count   = clkEn && counting && !startCmd;
    ctl.leadSel = (phase == PH_LEAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rateErr <= 1'b0;
    end else if (startCmd) begin
      if (cfgBad) begin
        phase   <= PH_IDLE;
        rateErr <= 1'b1;
      end else begin
        rateErr <= 1'b0;
        if (!oscReady)     phase <= PH_OSC;
        else if (singleIn) phase <= PH_CONV;
        else               phase <= PH_LEAD;
      end
    end else begin
      case (phase)
        PH_OSC:  if (oscReady) phase <= singleQ ? PH_CONV : PH_LEAD;
        PH_LEAD: if (done) phase <= PH_CONV;
        PH_CONV: if (done && singleQ) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        drdyN <= 1'b1;
    else if (done && phase == PH_CONV)                drdyN <= 1'b0;
    else if (dataRead || (nearEnd && phase == PH_CONV)) drdyN <= 1'b1;
  end

  AST_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> $past(done)); // R3

  AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(drdyN) && singleQ) |-> !busy); // R5

  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OSC && !oscReady) |=> !$fell(drdyN)); // R7

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rateErr |-> !busy); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !cfgBad) |=> busy); // R12

endmodule

// File: rtl/convseq_top.sv
module convseq_top
  import convseq_pkg::*;
#(
  parameter int PERIOD_SHIFT = 0,
  parameter int unsigned LEAD_NORMAL = 210,
  parameter int unsigned LEAD_TURBO = 114
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       startCmd,
  input  logic [1:0] opMode,
  input  logic [2:0] rateSel,
  input  logic       singleShot,
  input  logic       oscReady,
  input  logic       dataRead,
  output logic       drdyN,
  output logic       busy,
  output logic       rateErr
);

  seqCtl_t ctl;
  logic    done;
  logic    nearEnd;
  logic    singleQ;

  convseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .startCmd (startCmd),
    .modeIn   (opMode),
    .rateIn   (rateSel),
    .singleIn (singleShot),
    .oscReady (oscReady),
    .dataRead (dataRead),
    .done     (done),
    .nearEnd  (nearEnd),
    .singleQ  (singleQ),
    .ctl      (ctl),
    .drdyN    (drdyN),
    .busy     (busy),
    .rateErr  (rateErr)
  );

  convseq_datapath #(
    .PERIOD_SHIFT (PERIOD_SHIFT),
    .LEAD_NORMAL  (LEAD_NORMAL),
    .LEAD_TURBO   (LEAD_TURBO)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .modeIn   (opMode),
    .rateIn   (rateSel),
    .singleIn (singleShot),
    .done     (done),
    .nearEnd  (nearEnd),
    .singleQ  (singleQ)
  );

endmodule

// File: tb/convseq_top_test.sv
module convseq_top_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int SH = 6;

  logic clk = 1'b0;
  logic rstN, clkEn, startCmd, singleShot, oscReady, dataRead;
  logic [1:0] opMode;
  logic [2:0] rateSel;
  logic drdyN, busy, rateErr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  convseq_top #(.PERIOD_SHIFT(SH)) uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .startCmd(startCmd),
    .opMode(opMode), .rateSel(rateSel), .singleShot(singleShot),
    .oscReady(oscReady), .dataRead(dataRead),
    .drdyN(drdyN), .busy(busy), .rateErr(rateErr)
  );

  function automatic int expCont(int m, int r);
    int t0[7] = '{204768, 91120, 46128, 23664, 12464, 6896, 4144};
    int t1[7] = '{823120, 364560, 184592, 94736, 49936, 27664, 16656};
    int t2[7] = '{102384, 45560, 23064, 11832, 6232, 3448, 2072};
    if (m == 2) return t2[r] >> SH;
    if (m == 1) return t1[r] >> SH;
    return t0[r] >> SH;
  endfunction

  function automatic int expSingle(int m, int r);
    int tn[7] = '{204850, 91218, 46226, 23762, 12562, 6994, 4242};
    int tt[7] = '{102434, 45618, 23122, 11890, 6290, 3506, 2130};
    if (m == 2) return tt[r] >> SH;
    return tn[r] >> SH;
  endfunction

  function automatic int expLead(int m);
    return (m == 2) ? 114 : 210;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issueStart(input int m, input int r, input bit s);
    @(negedge clk);
    opMode = 2'(m); rateSel = 3'(r); singleShot = s;
    startCmd = 1'b1; dataRead = 1'b1;
    @(negedge clk);
    startCmd = 1'b0; dataRead = 1'b0;
  endtask

  // counts enabled ticks until the next low edge of drdyN
  task automatic waitFall(input bit alt, output int n, output int riseAt);
    int cyc;
    bit seenHigh;
    n = 0; riseAt = -1; cyc = 0;
    seenHigh = drdyN;
    forever begin
      clkEn = alt ? ~clkEn : 1'b1;
      @(posedge clk);
      if (clkEn) n++;
      cyc++;
      @(negedge clk);
      if (drdyN && !seenHigh) begin
        seenHigh = 1'b1;
        riseAt = n;
      end
      if (!drdyN && seenHigh) break;
      if (cyc > 30000) begin
        check(1'b0, "wait-limit", cyc, 0);
        break;
      end
    end
    clkEn = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, rise;
    rstN = 1'b0; clkEn = 1'b1; startCmd = 1'b0; singleShot = 1'b0;
    oscReady = 1'b1; dataRead = 1'b0; opMode = 2'd0; rateSel = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(drdyN == 1'b1, "R1 drdyN", drdyN, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rateErr == 1'b0, "R1 rateErr", rateErr, 0);

    // continuous sweep: R2 lead-in, R3 period, R6 early release, R12 busy
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 7; r++) begin
        issueStart(m, r, 1'b0);
        waitFall(1'b0, n, rise);
        check(n == expLead(m) + expCont(m, r), "R2 first edge", n, expLead(m) + expCont(m, r));
        check(busy == 1'b1, "R12 busy continuous", busy, 1);
        waitFall(1'b0, n, rise);
        check(n == expCont(m, r), "R3 period", n, expCont(m, r));
        check(rise == expCont(m, r) - 2, "R6 release before edge", rise, expCont(m, r) - 2);
      end
    end

    // single-shot sweep: R4 latency, R5 once then idle, R6 read release
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 7; r++) begin
        issueStart(m, r, 1'b1);
        check(busy == 1'b1, "R12 busy single", busy, 1);
        waitFall(1'b0, n, rise);
        check(n == expSingle(m, r), "R4 single latency", n, expSingle(m, r));
        check(busy == 1'b0, "R5 busy at edge", busy, 0);
        dataRead = 1'b1;
        @(negedge clk);
        dataRead = 1'b0;
        check(drdyN == 1'b1, "R6 read release", drdyN, 1);
        repeat (40) @(negedge clk);
        check(drdyN == 1'b1 && busy == 1'b0, "R5 no repeat", {30'd0, drdyN, busy}, 2);
      end
    end

    // R6 read strobe mid-period
    issueStart(2, 6, 1'b0);
    waitFall(1'b0, n, rise);
    dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
    check(drdyN == 1'b1, "R6 read mid-period", drdyN, 1);
    waitFall(1'b0, n, rise);
    check(n == expCont(2, 6) - 1, "R6 period after read", n, expCont(2, 6) - 1);

    // R9 restart mid-conversion
    issueStart(0, 6, 1'b0);
    repeat (100) @(negedge clk);
    check(drdyN == 1'b1, "R9 no edge yet", drdyN, 1);
    issueStart(2, 6, 1'b0);
    waitFall(1'b0, n, rise);
    check(n == 114 + expCont(2, 6), "R9 restart timing", n, 114 + expCont(2, 6));

    // R11 captured configuration
    issueStart(2, 6, 1'b0);
    @(negedge clk);
    opMode = 2'd0; rateSel = 3'd0; singleShot = 1'b1;
    waitFall(1'b0, n, rise);
    check(n == 114 + expCont(2, 6) - 1, "R11 first edge", n, 114 + expCont(2, 6) - 1);
    waitFall(1'b0, n, rise);
    check(n == expCont(2, 6), "R11 period", n, expCont(2, 6));
    check(busy == 1'b1, "R11 still continuous", busy, 1);

    // R10 gated ticks
    issueStart(2, 5, 1'b0);
    waitFall(1'b1, n, rise);
    check(n == 114 + expCont(2, 5), "R10 gated first", n, 114 + expCont(2, 5));
    waitFall(1'b1, n, rise);
    check(n == expCont(2, 5), "R10 gated period", n, expCont(2, 5));
    check(rise == expCont(2, 5) - 2, "R10 gated release", rise, expCont(2, 5) - 2);

    // R7 oscillator hold
    oscReady = 1'b0;
    issueStart(2, 6, 1'b1);
    repeat (20) @(negedge clk);
    check(drdyN == 1'b1, "R7 held drdyN", drdyN, 1);
    check(busy == 1'b1, "R7 held busy", busy, 1);
    oscReady = 1'b1;
    @(negedge clk);
    waitFall(1'b0, n, rise);
    check(n == expSingle(2, 6), "R7 after ready", n, expSingle(2, 6));

    // R8 reserved settings
    issueStart(2, 6, 1'b0);
    repeat (20) @(negedge clk);
    issueStart(0, 7, 1'b0);
    check(rateErr == 1'b1, "R8 index 7 err", rateErr, 1);
    check(busy == 1'b0, "R8 index 7 busy", busy, 0);
    repeat (300) @(negedge clk);
    check(drdyN == 1'b1, "R8 no conversion", drdyN, 1);
    issueStart(3, 0, 1'b0);
    check(rateErr == 1'b1, "R8 mode 3 err", rateErr, 1);
    check(busy == 1'b0, "R8 mode 3 busy", busy, 0);
    issueStart(2, 6, 1'b1);
    check(rateErr == 1'b0, "R8 err cleared", rateErr, 0);
    check(busy == 1'b1, "R8 valid start busy", busy, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule